// File: doc/BRIEF.md
# Multi-Sector Program Fetch Cache

This block sits between a signal-processing core's instruction fetch port and a synchronous program memory. It keeps a small number of sectors. Each sector is a full copy of one aligned, contiguous run of program words and carries its own tag. A fetch whose address falls inside a valid sector is answered in the same cycle. Any other fetch is a sector miss. On a sector miss one sector is picked as the victim, and the whole aligned run is read back from program memory, lowest word first. The requested word goes to the core as soon as it returns. The sector is loaded automatically as the program runs, and it only ever holds instructions, so nothing is written back.

The fetch interface is a request/ready pair. The core raises `fetch_req` with an address and holds both steady until `fetch_ready` is high at a clock edge. Program memory accepts one read per cycle on `mem_req`/`mem_addr` and returns the word on `mem_rdata` exactly `MEM_LAT` cycles later. Three control inputs change the behaviour:
- `lock_en` freezes the contents: misses are read straight from memory and nothing is replaced.
- `cache_off` sends every fetch to memory and ignores what is stored.
- `flush` invalidates every sector.

Top module: `sector_icache`

## Requirements
- R1: After reset `fetch_ready` and `mem_req` are low and every sector is invalid, so the first fetch of any address is a sector miss.
- R2: A fetch whose address lies in a valid sector gets `fetch_ready` high in the cycle it is presented, with the stored word and no memory read.
- R3: A sector miss with lock and disable low issues exactly `SECT_WORDS` memory reads, one per cycle, at consecutive addresses starting from the fetch address with its low log2(`SECT_WORDS`) bits cleared.
- R4: On a sector miss the requested word reaches the core `MEM_LAT` plus (address mod `SECT_WORDS`) cycles after the request is first presented, equal to the program memory contents.
- R5: Once a sector fill has completed, every word of that sector is served as a hit.
- R6: The victim is the lowest-numbered invalid sector if one exists, otherwise the least recently used sector; a hit or a completed fill makes that sector the most recently used.
- R7: While `lock_en` is high, hits are still served from the sectors, but a miss is served by one memory read with `fetch_ready` `MEM_LAT` cycles after the request, and no sector is replaced.
- R8: While `cache_off` is high, every fetch is served by one memory read with `fetch_ready` `MEM_LAT` cycles after the request, and the stored sectors are left intact for later use.
- R9: A single-cycle pulse on `flush` invalidates every sector by the next clock edge.
- R10: `fetch_ready` is never high while `fetch_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Core fetch request, held until served |
| fetch_addr | input | ADDR_W | Program word address of the fetch |
| fetch_ready | output | 1 | Fetch served this cycle |
| fetch_data | output | DATA_W | Instruction word for the fetch |
| mem_req | output | 1 | Program memory read strobe |
| mem_addr | output | ADDR_W | Program memory read address |
| mem_rdata | input | DATA_W | Word returned MEM_LAT cycles after the read |
| lock_en | input | 1 | Freeze contents, no replacement |
| cache_off | input | 1 | Send every fetch to program memory |
| flush | input | 1 | Invalidate all sectors |

## Verification
A straight sweep over consecutive addresses separates first-word fills from hits on words already loaded. A fresh pass over filled sectors confirms that whole sectors stay resident. Misses on middle and last words tell an early hand-off of the requested word apart from waiting for the whole sector. A reuse pattern that touches an old sector just before a new one arrives tells least-recently-used replacement apart from round-robin or fixed-index replacement. Runs with lock, disable and flush, followed by a long pseudo-random address stream over more sectors than the cache holds, show whether bypassed fetches are kept out of the contents and whether the modelled set of resident tags matches the block in latency, data and number of memory reads.

// File: rtl/sic_pkg.sv
package sic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_BYP  = 2'd2
  } sic_state_e;
endpackage

// File: rtl/sic_ret_pipe.sv
// Tracks when a read issued to program memory comes back.
module sic_ret_pipe #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  output logic ret_out
);
  logic [LAT-1:0] sh_q;
  logic [LAT-1:0] sh_d;

  generate
    if (LAT == 1) begin : g_one
      always_comb sh_d = req_in;
    end else begin : g_many
      always_comb sh_d = {sh_q[LAT-2:0], req_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign ret_out = sh_q[LAT-1];
endmodule

// File: rtl/sic_match.sv
// Parallel tag compare across all sectors.
module sic_match #(
  parameter int NUM_SECT = 4,
  parameter int TAG_W    = 8,
  localparam int IDX_W   = $clog2(NUM_SECT)
) (
  input  logic [NUM_SECT-1:0][TAG_W-1:0] tags,
  input  logic [NUM_SECT-1:0]            valid,
  input  logic [TAG_W-1:0]               probe,
  output logic                           hit,
  output logic [IDX_W-1:0]               hit_idx
);
  logic [NUM_SECT-1:0] eq;

  generate
    for (genvar g = 0; g < NUM_SECT; g++) begin : g_cmp
      assign eq[g] = valid[g] && (tags[g] == probe);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (eq[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/sic_lru.sv
// Recency ranks per sector (0 = most recent) and victim selection.
module sic_lru #(
  parameter int NUM_SECT = 4,
  localparam int IDX_W   = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                touch,
  input  logic [IDX_W-1:0]    touch_idx,
  input  logic [NUM_SECT-1:0] valid,
  output logic [IDX_W-1:0]    victim
);
  logic [NUM_SECT-1:0][IDX_W-1:0] rank_q;
  logic [NUM_SECT-1:0][IDX_W-1:0] rank_d;
  logic                           found;

  always_comb begin
    for (int i = 0; i < NUM_SECT; i++) begin
      if (IDX_W'(i) == touch_idx)                rank_d[i] = '0;
      else if (rank_q[i] < rank_q[touch_idx])    rank_d[i] = rank_q[i] + IDX_W'(1);
      else                                       rank_d[i] = rank_q[i];
    end
  end

  always_comb begin
    victim = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (!valid[i] && !found) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < NUM_SECT; i++) begin
        if (rank_q[i] == IDX_W'(NUM_SECT - 1)) victim = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SECT; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch) begin
      rank_q <= rank_d;
    end
  end
endmodule

// File: rtl/sector_icache.sv
module sector_icache
  import sic_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int SECT_WORDS = 4,
  parameter int NUM_SECT   = 4,
  parameter int MEM_LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              lock_en,
  input  logic              cache_off,
  input  logic              flush
);
  localparam int OFF_W = $clog2(SECT_WORDS);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(NUM_SECT);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SECT_WORDS - 1);

  sic_state_e                     state_q, state_d;
  logic [NUM_SECT-1:0]            valid_q, valid_d;
  logic [NUM_SECT-1:0][TAG_W-1:0] tag_q;
  logic [DATA_W-1:0]              data_q [NUM_SECT][SECT_WORDS];
  logic [IDX_W-1:0]               vict_q;
  logic [OFF_W-1:0]               iss_q, iss_d;
  logic [OFF_W-1:0]               ret_q, ret_d;
  logic                           busy_q, busy_d;
  logic                           served_q, served_d;
  logic                           void_q, void_d;

  logic [TAG_W-1:0] f_tag;
  logic [OFF_W-1:0] f_off;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] victim;
  logic             ret_valid;
  logic             start;
  logic             fill_done;
  logic             install;
  logic             touch;
  logic [IDX_W-1:0] touch_idx;

  assign f_tag = fetch_addr[ADDR_W-1:OFF_W];
  assign f_off = fetch_addr[OFF_W-1:0];

  sic_match #(.NUM_SECT(NUM_SECT), .TAG_W(TAG_W)) u_match (
    .tags(tag_q), .valid(valid_q), .probe(f_tag), .hit(hit), .hit_idx(hit_idx)
  );

  sic_lru #(.NUM_SECT(NUM_SECT)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx),
    .valid(valid_q), .victim(victim)
  );

  sic_ret_pipe #(.LAT(MEM_LAT)) u_ret (
    .clk(clk), .rst_n(rst_n), .req_in(mem_req), .ret_out(ret_valid)
  );

  // Control: decide hit / fill / bypass and sequence the sector read.
  always_comb begin
    state_d     = state_q;
    iss_d       = iss_q;
    ret_d       = ret_q;
    busy_d      = busy_q;
    served_d    = served_q;
    void_d      = void_q | flush;
    mem_req     = 1'b0;
    mem_addr    = fetch_addr;
    fetch_ready = 1'b0;
    fetch_data  = data_q[hit_idx][f_off];
    start       = 1'b0;
    fill_done   = 1'b0;
    install     = 1'b0;
    touch       = 1'b0;
    touch_idx   = hit_idx;
    unique case (state_q)
      ST_IDLE: begin
        if (fetch_req) begin
          if (cache_off || (!hit && lock_en)) begin
            mem_req = 1'b1;
            state_d = ST_BYP;
          end else if (hit) begin
            fetch_ready = 1'b1;
            touch       = 1'b1;
          end else begin
            mem_req  = 1'b1;
            mem_addr = {f_tag, OFF_W'(0)};
            start    = 1'b1;
            state_d  = ST_FILL;
            iss_d    = OFF_W'(1);
            busy_d   = 1'b1;
            ret_d    = '0;
            served_d = 1'b0;
            void_d   = flush;
          end
        end
      end
      ST_FILL: begin
        mem_req  = busy_q;
        mem_addr = {tag_q[vict_q], iss_q};
        if (busy_q) begin
          iss_d = iss_q + OFF_W'(1);
          if (iss_q == LAST_OFF) busy_d = 1'b0;
        end
        if (ret_valid) begin
          ret_d = ret_q + OFF_W'(1);
          if (!served_q && fetch_req && (fetch_addr == {tag_q[vict_q], ret_q})) begin
            fetch_ready = 1'b1;
            fetch_data  = mem_rdata;
            served_d    = 1'b1;
          end
          if (ret_q == LAST_OFF) begin
            fill_done = 1'b1;
            state_d   = ST_IDLE;
            // a flush seen during the fill leaves the sector invalid
            install   = !void_q && !flush;
            touch     = install;
            touch_idx = vict_q;
          end
        end
      end
      ST_BYP: begin
        if (ret_valid) begin
          fetch_ready = fetch_req;
          fetch_data  = mem_rdata;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    valid_d = valid_q;
    if (start)   valid_d[victim] = 1'b0;
    if (install) valid_d[vict_q] = 1'b1;
    if (flush)   valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      valid_q  <= '0;
      vict_q   <= '0;
      iss_q    <= '0;
      ret_q    <= '0;
      busy_q   <= 1'b0;
      served_q <= 1'b0;
      void_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      valid_q  <= valid_d;
      iss_q    <= iss_d;
      ret_q    <= ret_d;
      busy_q   <= busy_d;
      served_q <= served_d;
      void_q   <= void_d;
      if (start) vict_q <= victim;
    end
  end

  always_ff @(posedge clk) begin
    if (start) tag_q[victim] <= f_tag;
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_FILL && ret_valid) data_q[vict_q][ret_q] <= mem_rdata;
  end
endmodule

// File: rtl/sector_icache_chk.sv
module sector_icache_chk
  import sic_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int NUM_SECT = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fetch_req,
  input logic                fetch_ready,
  input logic                mem_req,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic                lock_en,
  input logic                cache_off,
  input logic                flush,
  input sic_state_e          st,
  input logic [NUM_SECT-1:0] valid
);
  a_r10_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> fetch_req);

  a_r2_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && fetch_ready) |-> !mem_req);

  a_r3_fill_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FILL && mem_req) |-> ($past(mem_req) && mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0));

  a_r7_lock_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && lock_en) |=> (st != ST_FILL));

  a_r8_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cache_off && fetch_req) |-> !fetch_ready);
endmodule

bind sector_icache sector_icache_chk #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_ready(fetch_ready),
  .mem_req(mem_req), .mem_addr(mem_addr), .lock_en(lock_en), .cache_off(cache_off),
  .flush(flush), .st(state_q), .valid(valid_q)
);

// File: tb/sector_icache_test.sv
module sector_icache_test;
  localparam int AW = 10, DW = 16, SW = 4, NS = 4, LAT = 2;

  logic          clk, rst_n;
  logic          fetch_req, fetch_ready, mem_req;
  logic [AW-1:0] fetch_addr, mem_addr;
  logic [DW-1:0] fetch_data, mem_rdata;
  logic          lock_en, cache_off, flush;

  int nchk = 0, nfail = 0, nreq = 0;

  sector_icache #(.ADDR_W(AW), .DATA_W(DW), .SECT_WORDS(SW), .NUM_SECT(NS), .MEM_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_data(fetch_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .lock_en(lock_en),
    .cache_off(cache_off), .flush(flush)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] mem_word(int a);
    return DW'(a * 13 + 'h1234);
  endfunction

  // program memory: fixed-latency read port
  logic [DW-1:0] mpipe [LAT];
  always @(posedge clk) begin
    for (int i = LAT - 1; i > 0; i--) mpipe[i] <= mpipe[i-1];
    mpipe[0] <= mem_req ? mem_word(int'(mem_addr)) : '0;
  end
  assign mem_rdata = mpipe[LAT-1];

  always @(posedge clk) if (rst_n && mem_req) nreq++;

  // reference state of resident tags
  int mtag [NS];
  bit mval [NS];
  int mrank [NS];

  task automatic m_touch(int s);
    for (int j = 0; j < NS; j++) if (j != s && mrank[j] < mrank[s]) mrank[j]++;
    mrank[s] = 0;
  endtask

  function automatic int m_victim();
    for (int i = 0; i < NS; i++) if (!mval[i]) return i;
    for (int i = 0; i < NS; i++) if (mrank[i] == NS - 1) return i;
    return 0;
  endfunction

  task automatic chk(string ph, string rq, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", ph, rq, act, exp);
    end
  endtask

  task automatic do_fetch(int a, string ph);
    int lat, n0, hs, kind, v;
    logic [DW-1:0] d;
    hs = -1;
    for (int i = 0; i < NS; i++) if (mval[i] && mtag[i] == a / SW) hs = i;
    if (cache_off || (hs < 0 && lock_en)) kind = 2;
    else if (hs >= 0) kind = 0;
    else kind = 1;
    n0 = nreq;
    @(negedge clk);
    fetch_req = 1'b1;
    fetch_addr = AW'(a);
    lat = 0;
    #4;
    while (!fetch_ready && lat < 100) begin
      @(negedge clk); #4; lat++;
    end
    d = fetch_data;
    @(posedge clk); #1;
    fetch_req = 1'b0;
    repeat (8) @(negedge clk);
    if (kind == 0) begin
      m_touch(hs);
      chk(ph, "R2 latency", lat, 0);
      chk(ph, "R2 data", int'(d), int'(mem_word(a)));
      chk(ph, "R2 reads", nreq - n0, 0);
    end else if (kind == 1) begin
      v = m_victim();
      mtag[v] = a / SW; mval[v] = 1'b1; m_touch(v);
      chk(ph, "R4 latency", lat, LAT + a % SW);
      chk(ph, "R4 data", int'(d), int'(mem_word(a)));
      chk(ph, "R3 reads", nreq - n0, SW);
    end else begin
      chk(ph, cache_off ? "R8 latency" : "R7 latency", lat, LAT);
      chk(ph, cache_off ? "R8 data" : "R7 data", int'(d), int'(mem_word(a)));
      chk(ph, cache_off ? "R8 reads" : "R7 reads", nreq - n0, 1);
    end
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < NS; i++) mval[i] = 1'b0;
  endtask

  initial begin
    #1_500_000;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; fetch_req = 1'b0; fetch_addr = '0;
    lock_en = 1'b0; cache_off = 1'b0; flush = 1'b0;
    for (int i = 0; i < NS; i++) begin mtag[i] = 0; mval[i] = 1'b0; mrank[i] = i; end
    repeat (3) @(negedge clk);
    chk("reset", "R1 ready", int'(fetch_ready), 0);
    chk("reset", "R1 mem_req", int'(mem_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 first fetch misses; sequential sweep covers fills and hits
    for (int a = 0; a < 32; a++) do_fetch(a, "R1 sweep");
    // R5 resident sectors serve every word
    for (int a = 16; a < 32; a++) do_fetch(a, "R5 resident");
    // R4 misses on middle and last words
    do_fetch('h43, "R4 offset");
    do_fetch('h81, "R4 offset");
    do_fetch('hC2, "R4 offset");
    // R6 reuse pattern
    pulse_flush();
    do_fetch('h100, "R6 lru"); do_fetch('h110, "R6 lru");
    do_fetch('h120, "R6 lru"); do_fetch('h130, "R6 lru");
    do_fetch('h101, "R6 lru"); do_fetch('h140, "R6 lru");
    do_fetch('h110, "R6 lru"); do_fetch('h102, "R6 lru");
    do_fetch('h133, "R6 lru"); do_fetch('h121, "R6 lru");
    // R7 lock
    @(negedge clk); lock_en = 1'b1;
    do_fetch('h200, "R7 lock"); do_fetch('h201, "R7 lock");
    do_fetch('h100, "R7 lock");
    @(negedge clk); lock_en = 1'b0;
    // R8 disable
    @(negedge clk); cache_off = 1'b1;
    do_fetch('h100, "R8 off"); do_fetch('h300, "R8 off");
    @(negedge clk); cache_off = 1'b0;
    do_fetch('h100, "R8 kept");
    // R9 flush
    pulse_flush();
    do_fetch('h100, "R9 flush");
    do_fetch('h103, "R9 flush");
    // R10 no ready without request, on a resident address
    @(negedge clk); fetch_addr = AW'('h101); #4;
    chk("idle", "R10 ready", int'(fetch_ready), 0);
    // R6 pseudo-random stream over 16 sectors
    lf = 16'hACE1;
    for (int k = 0; k < 200; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_fetch(int'(lf[5:0]), "R6 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule